// File: doc/BRIEF.md
# Split Program Counter Unit

This block produces the fetch address of a small processor core. It holds a 13-bit program counter and a separate 5-bit latch register that supplies the upper address bits. The counter moves in one of three ways: it steps to the next address, it loads an 11-bit literal for a jump or call, or it takes new low-byte data. A low-byte write is how software builds a computed jump or a table lookup. In both the jump and the low-byte cases the bits the instruction cannot reach are filled from the latch. They are never kept from the old counter value.

The latch is written only through its own port, and its readback port always shows the stored latch value. When several strobes arrive in the same cycle, a fixed priority picks one action. The latch contents used in a cycle are the values held before that cycle's edge. Return-address storage is outside this block.

Top module: `pc_split_unit`

## Requirements
- R1: After reset the fetch address `pc_o` is 0x0000 and `latch_q_o` is 0x00.
- R2: An increment strobe advances `pc_o` by one on the next edge, and 0x1FFF is followed by 0x0000.
- R3: A jump strobe loads `pc_o` with the latch bits 4:3 as address bits 12:11 and the 11-bit literal as address bits 10:0.
- R4: A low-byte write loads `pc_o` with the latch bits 4:0 as address bits 12:8 and the written byte as address bits 7:0.
- R5: A latch write changes only `latch_q_o`. Without a counter strobe, `pc_o` keeps its value, and `latch_q_o` shows the stored latch even when it differs from `pc_o[12:8]`.
- R6: With no counter strobe asserted, `pc_o` holds its value.
- R7: When strobes coincide, a low-byte write wins over a jump, and a jump wins over an increment.
- R8: A latch write made in the same cycle as a jump or low-byte write does not affect that cycle's target. The new latch value is visible on `latch_q_o` one edge later.
- R9: `pc_low_o` always equals bits 7:0 of `pc_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| inc_i | input | 1 | Step to the next address |
| jmp_i | input | 1 | Jump or call strobe |
| jmp_lit_i | input | 11 | Literal target of a jump or call |
| low_wr_i | input | 1 | Write strobe for the low byte |
| low_data_i | input | 8 | Data for a low-byte write |
| latch_wr_i | input | 1 | Write strobe for the upper-bits latch |
| latch_data_i | input | 5 | Data for the latch |
| latch_q_o | output | 5 | Stored latch value |
| pc_low_o | output | 8 | Low byte of the counter, readable as a register |
| pc_o | output | 13 | Current fetch address |

## Verification
The bench drives the counter past 0x1FFF. A design that carried into a fourteenth bit or saturated at the top would not return to zero there.

It jumps with latch values whose bits 4:3 differ from the current page. A design that kept the old upper bits, or took the wrong latch slice, would land on the wrong page.

It writes the latch in the same cycle as a jump. A design that forwarded the new latch value into the target would compute a different address.

It asserts all three counter strobes together, and then a jump with an increment. A wrong priority would show up as a stepped address or a literal target where a loaded byte or a jump was expected.

It also reads back the latch while the counter's upper bits hold a different value. A design that mirrored the live counter bits onto the readback port would fail that check.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  typedef enum logic [1:0] {
    PC_HOLD = 2'd0,
    PC_STEP = 2'd1,
    PC_JUMP = 2'd2,
    PC_LOAD = 2'd3
  } pc_op_e;
endpackage

// File: rtl/pcu_op_arb.sv
module pcu_op_arb
  import pcu_pkg::*;
(
  input  logic   inc_i,
  input  logic   jmp_i,
  input  logic   low_wr_i,
  output pc_op_e op_o,
  output logic   step_ev_o,
  output logic   jump_ev_o,
  output logic   load_ev_o
);
  // R7: low-byte write > jump > increment
  assign load_ev_o = low_wr_i;
  assign jump_ev_o = jmp_i & ~low_wr_i;
  assign step_ev_o = inc_i & ~jmp_i & ~low_wr_i;

  always_comb begin
    if (load_ev_o)      op_o = PC_LOAD;
    else if (jump_ev_o) op_o = PC_JUMP;
    else if (step_ev_o) op_o = PC_STEP;
    else                op_o = PC_HOLD;
  end
endmodule

// File: rtl/pcu_next_addr.sv
module pcu_next_addr
  import pcu_pkg::*;
#(
  parameter int PC_W  = 13,
  parameter int LOW_W = 8,
  parameter int LIT_W = 11,
  localparam int HI_W = PC_W - LOW_W,
  localparam int PG_W = PC_W - LIT_W
) (
  input  pc_op_e           op_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic [HI_W-1:0]  latch_i,
  input  logic [LIT_W-1:0] lit_i,
  input  logic [LOW_W-1:0] low_data_i,
  output logic [PC_W-1:0]  pc_d_o
);
  // Next sequential address, wrapping at the top of the space (R2)
  function automatic logic [PC_W-1:0] step_addr(input logic [PC_W-1:0] pc);
    return pc + {{(PC_W-1){1'b0}}, 1'b1};
  endfunction

  // Page bits from the latch top, literal below (R3)
  function automatic logic [PC_W-1:0] jump_addr(input logic [HI_W-1:0] lat,
                                                input logic [LIT_W-1:0] lit);
    return {lat[HI_W-1 -: PG_W], lit};
  endfunction

  // Whole latch on top, written byte below (R4)
  function automatic logic [PC_W-1:0] load_addr(input logic [HI_W-1:0] lat,
                                                input logic [LOW_W-1:0] dat);
    return {lat, dat};
  endfunction

  always_comb begin
    unique case (op_i)
      PC_STEP: pc_d_o = step_addr(pc_i);
      PC_JUMP: pc_d_o = jump_addr(latch_i, lit_i);
      PC_LOAD: pc_d_o = load_addr(latch_i, low_data_i);
      default: pc_d_o = pc_i;
    endcase
  end
endmodule

// File: rtl/pcu_latch_reg.sv
module pcu_latch_reg #(
  parameter int HI_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_i,
  input  logic [HI_W-1:0] data_i,
  output logic [HI_W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q_o <= '0;
    else if (wr_i) q_o <= data_i;
  end
endmodule

// File: rtl/pc_split_unit.sv
module pc_split_unit
  import pcu_pkg::*;
#(
  parameter int PC_W  = 13,
  parameter int LOW_W = 8,
  parameter int LIT_W = 11,
  localparam int HI_W = PC_W - LOW_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  input  logic             jmp_i,
  input  logic [LIT_W-1:0] jmp_lit_i,
  input  logic             low_wr_i,
  input  logic [LOW_W-1:0] low_data_i,
  input  logic             latch_wr_i,
  input  logic [HI_W-1:0]  latch_data_i,
  output logic [HI_W-1:0]  latch_q_o,
  output logic [LOW_W-1:0] pc_low_o,
  output logic [PC_W-1:0]  pc_o
);
  pc_op_e          op;
  logic            step_ev, jump_ev, load_ev;
  logic [PC_W-1:0] pc_q, pc_d;

  pcu_op_arb u_arb (
    .inc_i     (inc_i),
    .jmp_i     (jmp_i),
    .low_wr_i  (low_wr_i),
    .op_o      (op),
    .step_ev_o (step_ev),
    .jump_ev_o (jump_ev),
    .load_ev_o (load_ev)
  );

  pcu_latch_reg #(.HI_W(HI_W)) u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_i   (latch_wr_i),
    .data_i (latch_data_i),
    .q_o    (latch_q_o)
  );

  pcu_next_addr #(.PC_W(PC_W), .LOW_W(LOW_W), .LIT_W(LIT_W)) u_next (
    .op_i       (op),
    .pc_i       (pc_q),
    .latch_i    (latch_q_o),
    .lit_i      (jmp_lit_i),
    .low_data_i (low_data_i),
    .pc_d_o     (pc_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  assign pc_o     = pc_q;
  assign pc_low_o = pc_q[LOW_W-1:0];
endmodule

// File: rtl/pcu_chk.sv
module pcu_chk #(
  parameter int PC_W  = 13,
  parameter int LOW_W = 8,
  parameter int LIT_W = 11,
  localparam int HI_W = PC_W - LOW_W,
  localparam int PG_W = PC_W - LIT_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             step_ev,
  input logic             jump_ev,
  input logic             load_ev,
  input logic             latch_wr_i,
  input logic [LIT_W-1:0] jmp_lit_i,
  input logic [LOW_W-1:0] low_data_i,
  input logic [HI_W-1:0]  latch_q_o,
  input logic [PC_W-1:0]  pc_o
);
  // R2
  inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_ev |=> pc_o == $past(pc_o) + {{(PC_W-1){1'b0}}, 1'b1});

  // R3
  jump_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jump_ev |=> pc_o == {$past(latch_q_o[HI_W-1 -: PG_W]), $past(jmp_lit_i)});

  // R4
  low_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> pc_o == {$past(latch_q_o), $past(low_data_i)});

  // R6
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_ev || jump_ev || load_ev) |=> $stable(pc_o));

  // R5
  latch_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_wr_i |=> $stable(latch_q_o));

  // R7
  one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({step_ev, jump_ev, load_ev}));
endmodule

bind pc_split_unit pcu_chk #(.PC_W(PC_W), .LOW_W(LOW_W), .LIT_W(LIT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .step_ev    (step_ev),
  .jump_ev    (jump_ev),
  .load_ev    (load_ev),
  .latch_wr_i (latch_wr_i),
  .jmp_lit_i  (jmp_lit_i),
  .low_data_i (low_data_i),
  .latch_q_o  (latch_q_o),
  .pc_o       (pc_o)
);

// File: tb/sim_pc_split_unit.sv
module sim_pc_split_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inc_i = 1'b0, jmp_i = 1'b0, low_wr_i = 1'b0, latch_wr_i = 1'b0;
  logic [10:0] jmp_lit_i = '0;
  logic [7:0]  low_data_i = '0;
  logic [4:0]  latch_data_i = '0;
  logic [4:0]  latch_q_o;
  logic [7:0]  pc_low_o;
  logic [12:0] pc_o;

  int total = 0, bad = 0;
  bit finished = 1'b0;

  typedef struct {
    int    pc;
    int    lat;
    string tag;
  } exp_t;
  exp_t sb[$];

  int m_pc = 0, m_lat = 0;

  always #4 clk = ~clk;

  pc_split_unit u0 (
    .clk(clk), .rst_n(rst_n), .inc_i(inc_i), .jmp_i(jmp_i), .jmp_lit_i(jmp_lit_i),
    .low_wr_i(low_wr_i), .low_data_i(low_data_i), .latch_wr_i(latch_wr_i),
    .latch_data_i(latch_data_i), .latch_q_o(latch_q_o), .pc_low_o(pc_low_o), .pc_o(pc_o)
  );

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and predicts its result
  task automatic drive(bit inc, bit jmp, int lit, bit lw, int ld, bit aw, int ad, string tag);
    exp_t e;
    @(negedge clk);
    inc_i = inc; jmp_i = jmp; jmp_lit_i = 11'(lit);
    low_wr_i = lw; low_data_i = 8'(ld); latch_wr_i = aw; latch_data_i = 5'(ad);
    if (lw)       m_pc = m_lat * 256 + ld;
    else if (jmp) m_pc = (m_lat / 8) * 2048 + lit;
    else if (inc) m_pc = (m_pc + 1) % 8192;
    if (aw) m_lat = ad;
    e.pc = m_pc; e.lat = m_lat; e.tag = tag;
    @(posedge clk);
    #1;
    sb.push_back(e);
  endtask

  // Monitor: compares outputs at the falling edge after each result edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check({e.tag, " pc"}, int'(pc_o), e.pc);
      check({e.tag, " latch"}, int'(latch_q_o), e.lat);
      check("R9 low byte", int'(pc_low_o), e.pc % 256);
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset pc", int'(pc_o), 0);
    check("R1 reset latch", int'(latch_q_o), 0);
    drive(0,0,0,     0,0,    0,0,    "R6 idle");
    drive(1,0,0,     0,0,    0,0,    "R2 inc");
    drive(1,0,0,     0,0,    0,0,    "R2 inc");
    drive(1,0,0,     0,0,    0,0,    "R2 inc");
    drive(0,0,0,     0,0,    1,'h1F, "R5 latch only");
    drive(0,1,'h7FF, 0,0,    0,0,    "R3 jump top");
    drive(1,0,0,     0,0,    0,0,    "R2 wrap");
    drive(0,0,0,     1,'h42, 0,0,    "R4 low write");
    drive(0,1,'h123, 0,0,    1,'h0A, "R8 jump old latch");
    drive(0,0,0,     1,'h10, 0,0,    "R4 low write new latch");
    drive(0,1,'h555, 0,0,    0,0,    "R3 jump page 1");
    drive(1,1,'h001, 1,'h99, 0,0,    "R7 all strobes");
    drive(1,1,'h002, 0,0,    0,0,    "R7 jump over inc");
    drive(0,0,0,     0,0,    1,'h10, "R5 readback differs");
    drive(0,0,0,     1,'hFF, 1,'h03, "R8 load old latch");
    drive(0,0,0,     0,0,    0,0,    "R6 hold");
    @(negedge clk);
    inc_i = 0; jmp_i = 0; low_wr_i = 0; latch_wr_i = 0;
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #20000;
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule